// File: doc/BRIEF.md
# Linked-List Transfer Chaining Engine

This block holds the register set of four transfer channels. When a channel's current transfer ends, the block can load that channel's next transfer from memory. Each channel has five 32-bit registers: a control word, a source address, a destination address, a count and a next-descriptor pointer. Software programs the first transfer through a small write port. A one-cycle pulse on `xfer_done` stands in for the data mover finishing a transfer.

On that pulse, if the channel is set to chain and its pointer is nonzero, the engine reads a five-word descriptor at the pointer through a simple word-read port. The words arrive as control, source, destination, count and next pointer. The engine then writes all five into the channel at once, and the channel carries on without software help. A zero pointer, or a cleared chain bit, ends the chain instead: the channel turns off and raises its terminal-count flag.

One fetch sequencer serves all channels. Requests are granted by fixed priority, and a fetch that has started always runs to completion.

Top module: `sg_chain_engine`

## Requirements
- R1: After reset every channel register reads zero, `ch_en` and `ch_tc` are all zero, and `fetch_busy` and `mem_req` are low.
- R2: A config write selects a register with `cfg_sel`: 0 control, 1 source, 2 destination, 3 count, 4 next pointer. A control write is taken unless a reload is pending or running for that channel, and it clears that channel's `ch_tc`. Writes to the other four registers are taken only while control bit 0 (enable) is 0. The next pointer always stores bits 1:0 as zero.
- R3: `xfer_done` on an enabled channel reads five words when both of these hold: control bit 1 (chain) is 1, and the next pointer is nonzero. The reads go to pointer+0, +4, +8, +12 and +16, one `mem_req` each, in that order. Every read address has bits 1:0 zero, and `mem_req` is high only while `fetch_busy` is high.
- R4: At the end of a fetch, all five fetched words land in the channel registers on the same clock edge. Control bit 0 is forced to 1 and pointer bits 1:0 are forced to 0, so the channel stays enabled.
- R5: `xfer_done` on an enabled channel ends the chain when the chain bit is 0 or the next pointer is zero. Control bit 0 is cleared, `ch_tc` is set, and no memory read is made.
- R6: `xfer_done` has no effect on a channel that is disabled, or whose reload is pending or in progress.
- R7: When several channels await a reload, the lowest-numbered one is fetched first. `fetch_ch` does not change until that fetch ends.
- R8: Each word waits for `mem_rvalid`. When data is valid in the first cycle after the request, a fetch keeps `fetch_busy` high for 16 cycles. Each extra wait cycle adds one cycle per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_ch | input | CHW | Channel written |
| cfg_sel | input | 3 | Register written (0 ctrl, 1 src, 2 dst, 3 count, 4 next) |
| cfg_wdata | input | W | Write data |
| xfer_done | input | NCH | Per-channel transfer-finished pulse |
| mem_req | output | 1 | Word read request |
| mem_addr | output | W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| rd_ch | input | CHW | Channel shown on the rd_* outputs |
| rd_ctrl | output | W | Control register of rd_ch |
| rd_src | output | W | Source address of rd_ch |
| rd_dst | output | W | Destination address of rd_ch |
| rd_cnt | output | W | Count of rd_ch |
| rd_next | output | W | Next-descriptor pointer of rd_ch |
| ch_en | output | NCH | Control bit 0 of each channel |
| ch_tc | output | NCH | Terminal-count flag of each channel |
| fetch_busy | output | 1 | A descriptor fetch is running |
| fetch_ch | output | CHW | Channel being fetched |

## Verification
The chaining path runs through a two-descriptor chain. The first fetch sees a three-cycle memory and the second a one-cycle memory, so the busy-length check separates a sequencer that honours the valid handshake from one that assumes fixed latency. A final done pulse on the zero-pointer descriptor, and another on a non-chaining channel, show that chains end without any read. A simultaneous done pulse on three chaining channels, plus a repeat pulse during the first fetch, exposes errors in priority, in the order of read addresses and in the guard against pending reloads. The guard tests also cover writes to an enabled channel and done pulses on a disabled one.

// File: rtl/sg_chain_engine.sv
module sg_chain_engine #(
  parameter int NCH = 4,
  parameter int W = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [2:0]     cfg_sel,
  input  logic [W-1:0]   cfg_wdata,
  input  logic [NCH-1:0] xfer_done,
  output logic           mem_req,
  output logic [W-1:0]   mem_addr,
  input  logic           mem_rvalid,
  input  logic [W-1:0]   mem_rdata,
  input  logic [CHW-1:0] rd_ch,
  output logic [W-1:0]   rd_ctrl,
  output logic [W-1:0]   rd_src,
  output logic [W-1:0]   rd_dst,
  output logic [W-1:0]   rd_cnt,
  output logic [W-1:0]   rd_next,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] ch_tc,
  output logic           fetch_busy,
  output logic [CHW-1:0] fetch_ch
);
  localparam int NWORD = 5;
  localparam int WIX = $clog2(NWORD);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_STORE, S_COMMIT} st_t;

  st_t            st;
  logic [W-1:0]   ctrl_q [NCH];
  logic [W-1:0]   src_q  [NCH];
  logic [W-1:0]   dst_q  [NCH];
  logic [W-1:0]   cnt_q  [NCH];
  logic [W-1:0]   nxt_q  [NCH];
  logic [NCH-1:0] pend_q, tc_q;
  logic [W-1:0]   wbuf   [NWORD];
  logic [WIX-1:0] widx;
  logic [CHW-1:0] sel_q;
  logic [W-1:0]   base_q;
  logic [CHW-1:0] win;
  logic           commit;

  assign commit     = (st == S_COMMIT);
  assign mem_req    = (st == S_REQ);
  assign mem_addr   = base_q + W'({widx, 2'b00});
  assign fetch_busy = (st != S_IDLE);
  assign fetch_ch   = sel_q;
  assign ch_tc      = tc_q;

  assign rd_ctrl = ctrl_q[rd_ch];
  assign rd_src  = src_q[rd_ch];
  assign rd_dst  = dst_q[rd_ch];
  assign rd_cnt  = cnt_q[rd_ch];
  assign rd_next = nxt_q[rd_ch];

  always_comb begin
    for (int i = 0; i < NCH; i++) ch_en[i] = ctrl_q[i][0];
  end

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) win = CHW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      tc_q   <= '0;
      for (int i = 0; i < NCH; i++) begin
        ctrl_q[i] <= '0;
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        cnt_q[i]  <= '0;
        nxt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (commit && sel_q == CHW'(i)) begin
          ctrl_q[i] <= wbuf[0] | W'(1);
          src_q[i]  <= wbuf[1];
          dst_q[i]  <= wbuf[2];
          cnt_q[i]  <= wbuf[3];
          nxt_q[i]  <= {wbuf[4][W-1:2], 2'b00};
          pend_q[i] <= 1'b0;
        end else if (xfer_done[i] && ctrl_q[i][0] && !pend_q[i]) begin
          if (ctrl_q[i][1] && nxt_q[i] != '0) begin
            pend_q[i] <= 1'b1;
          end else begin
            ctrl_q[i][0] <= 1'b0;
            tc_q[i]      <= 1'b1;
          end
        end else if (cfg_we && cfg_ch == CHW'(i) && !pend_q[i]) begin
          case (cfg_sel)
            3'd0: begin
              ctrl_q[i] <= cfg_wdata;
              tc_q[i]   <= 1'b0;
            end
            3'd1: if (!ctrl_q[i][0]) src_q[i] <= cfg_wdata;
            3'd2: if (!ctrl_q[i][0]) dst_q[i] <= cfg_wdata;
            3'd3: if (!ctrl_q[i][0]) cnt_q[i] <= cfg_wdata;
            3'd4: if (!ctrl_q[i][0]) nxt_q[i] <= {cfg_wdata[W-1:2], 2'b00};
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      widx   <= '0;
      sel_q  <= '0;
      base_q <= '0;
      for (int k = 0; k < NWORD; k++) wbuf[k] <= '0;
    end else begin
      case (st)
        S_IDLE: if (pend_q != '0) begin
          sel_q  <= win;
          base_q <= nxt_q[win];
          widx   <= '0;
          st     <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          wbuf[widx] <= mem_rdata;
          st         <= S_STORE;
        end
        S_STORE: if (widx == WIX'(NWORD - 1)) begin
          st <= S_COMMIT;
        end else begin
          widx <= widx + WIX'(1);
          st   <= S_REQ;
        end
        S_COMMIT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sg_chain_engine_chk #(
  parameter int NCH = 4,
  parameter int W = 32,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic [W-1:0]   mem_addr,
  input logic           fetch_busy,
  input logic [CHW-1:0] fetch_ch,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_tc,
  input logic [NCH-1:0] pend
);
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> fetch_busy); // R3
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R3
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_busy && $past(fetch_busy)) |-> $stable(fetch_ch)); // R7
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_busy) |-> (($past(pend) & ((NCH'(1) << fetch_ch) - NCH'(1))) == '0)); // R7
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_busy) |-> (($past(pend) & (NCH'(1) << fetch_ch)) != '0)); // R7
  AST_COMMIT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_busy) |-> (ch_en[fetch_ch] && !pend[fetch_ch])); // R4
  AST_TC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_tc & ~$past(ch_tc)) & ch_en) == '0); // R5
  AST_PEND_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~ch_en) == '0); // R6
endmodule

bind sg_chain_engine sg_chain_engine_chk #(.NCH(NCH), .W(W), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .fetch_busy(fetch_busy), .fetch_ch(fetch_ch), .ch_en(ch_en),
  .ch_tc(ch_tc), .pend(pend_q)
);

// File: tb/sg_chain_engine_tb.sv
module sg_chain_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  xfer_done = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic [1:0]  rd_ch = '0;
  logic [31:0] rd_ctrl, rd_src, rd_dst, rd_cnt, rd_next;
  logic [3:0]  ch_en, ch_tc;
  logic        fetch_busy;
  logic [1:0]  fetch_ch;

  int nchk = 0;
  int nerr = 0;
  int busy_cyc = 0;
  int mem_lat = 1;
  int lat_cnt = 0;
  logic [31:0] raddr = '0;
  logic [31:0] mem [0:255];
  logic [31:0] exp_q [$];
  logic [31:0] popped;

  always #10 clk = ~clk;

  sg_chain_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_done(xfer_done), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rd_ch(rd_ch), .rd_ctrl(rd_ctrl),
    .rd_src(rd_src), .rd_dst(rd_dst), .rd_cnt(rd_cnt), .rd_next(rd_next), .ch_en(ch_en),
    .ch_tc(ch_tc), .fetch_busy(fetch_busy), .fetch_ch(fetch_ch)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      lat_cnt <= mem_lat;
      raddr   <= mem_addr;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
    end
  end
  assign mem_rvalid = (lat_cnt == 1);
  assign mem_rdata  = mem[raddr[9:2]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fetch_busy) busy_cyc++;
    if (rst_n && mem_req) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected read", mem_addr, 32'hFFFF_FFFF);
      end else begin
        popped = exp_q.pop_front();
        chk("R3 read address", mem_addr, popped);
      end
    end
  end

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, s, d, n, nx);
    mem[a/4] = c; mem[a/4+1] = s; mem[a/4+2] = d; mem[a/4+3] = n; mem[a/4+4] = nx;
  endtask

  task automatic expect_fetch(input logic [31:0] a);
    for (int k = 0; k < 5; k++) exp_q.push_back(a + 32'(4 * k));
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    busy_cyc = 0;
    xfer_done = m;
    @(negedge clk);
    xfer_done = '0;
    repeat (2) @(negedge clk);
    while (fetch_busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_regs(input string tag, input int ch, input logic [31:0] c, s, d, n, nx);
    rd_ch = 2'(ch);
    #1;
    chk({tag, " ctrl"}, rd_ctrl, c);
    chk({tag, " src"}, rd_src, s);
    chk({tag, " dst"}, rd_dst, d);
    chk({tag, " cnt"}, rd_cnt, n);
    chk({tag, " next"}, rd_next, nx);
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put_desc(32'h40, 32'h0000_0A03, 32'h1000, 32'h2000, 32'd16, 32'h60);
    put_desc(32'h60, 32'h0000_0002, 32'h1100, 32'h2100, 32'd8, 32'h0);
    put_desc(32'h80, 32'h0000_0C01, 32'h3000, 32'h4000, 32'd4, 32'h0);
    put_desc(32'hA0, 32'h0000_0D01, 32'h3100, 32'h4100, 32'd5, 32'h0);
    put_desc(32'hC0, 32'h0000_0E01, 32'h3200, 32'h4200, 32'd6, 32'h0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_regs("R1 ch0", 0, 0, 0, 0, 0, 0);
    chk("R1 en", 32'(ch_en), 0);
    chk("R1 tc", 32'(ch_tc), 0);
    chk("R1 busy", 32'(fetch_busy), 0);
    chk("R1 req", 32'(mem_req), 0);

    // R2 programming while disabled, pointer alignment
    wr(0, 1, 32'h0500); wr(0, 2, 32'h0600); wr(0, 3, 32'd32); wr(0, 4, 32'h43);
    chk_regs("R2 program", 0, 0, 32'h0500, 32'h0600, 32'd32, 32'h40);
    wr(0, 0, 32'h3);
    wr(0, 1, 32'hDEAD);
    wr(0, 4, 32'h80);
    chk_regs("R2 locked while enabled", 0, 32'h3, 32'h0500, 32'h0600, 32'd32, 32'h40);

    // R3 R4 R8 first link, slow memory
    mem_lat = 3;
    expect_fetch(32'h40);
    pulse(4'b0001);
    chk_regs("R4 link A", 0, 32'h0A03, 32'h1000, 32'h2000, 32'd16, 32'h60);
    chk("R8 busy slow", busy_cyc, 26);
    chk("R4 en", 32'(ch_en[0]), 1);

    // R3 R4 R8 second link, fast memory, enable forced
    mem_lat = 1;
    expect_fetch(32'h60);
    pulse(4'b0001);
    chk_regs("R4 link B", 0, 32'h3, 32'h1100, 32'h2100, 32'd8, 32'h0);
    chk("R8 busy fast", busy_cyc, 16);

    // R5 zero pointer ends chain
    pulse(4'b0001);
    chk("R5 en off", 32'(ch_en[0]), 0);
    chk("R5 tc", 32'(ch_tc[0]), 1);
    chk("R5 no fetch", busy_cyc, 0);

    // R6 done on disabled channel
    pulse(4'b0001);
    chk_regs("R6 disabled", 0, 32'h2, 32'h1100, 32'h2100, 32'd8, 32'h0);
    chk("R6 tc kept", 32'(ch_tc[0]), 1);
    wr(0, 0, 32'h0);
    chk("R2 tc cleared", 32'(ch_tc[0]), 0);

    // R7 priority; R6 repeat done during fetch
    wr(1, 4, 32'h80); wr(1, 0, 32'h3);
    wr(2, 4, 32'hA0); wr(2, 0, 32'h3);
    wr(3, 4, 32'hC0); wr(3, 0, 32'h3);
    expect_fetch(32'h80); expect_fetch(32'hA0); expect_fetch(32'hC0);
    @(negedge clk);
    xfer_done = 4'b1110;
    @(negedge clk);
    xfer_done = 4'b0000;
    repeat (4) @(negedge clk);
    xfer_done = 4'b0010;
    @(negedge clk);
    xfer_done = 4'b0000;
    while (fetch_busy || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7 all drained", 32'(exp_q.size()), 0);
    chk_regs("R7 ch1", 1, 32'h0C01, 32'h3000, 32'h4000, 32'd4, 32'h0);
    chk_regs("R7 ch2", 2, 32'h0D01, 32'h3100, 32'h4100, 32'd5, 32'h0);
    chk_regs("R7 ch3", 3, 32'h0E01, 32'h3200, 32'h4200, 32'd6, 32'h0);

    // R5 chain bit clear ends without read
    pulse(4'b0100);
    chk("R5 chain bit off en", 32'(ch_en[2]), 0);
    chk("R5 chain bit off tc", 32'(ch_tc[2]), 1);
    chk("R5 chain bit off busy", busy_cyc, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule